// File: doc/BRIEF.md
# Two-Way Write-Back Level-1 Data Cache

This block is a 4 KB level-1 cache that sits between a processor load/store port and a slower line-oriented memory. Storage is arranged as 32 sets of two ways with 64-byte lines. Each lookup reads both ways of the addressed set in one access. A tag comparison then picks which of the two stored words is returned. Loads and stores that hit finish in the cycle they are presented. Stores update the line in place and mark it modified. Main memory sees those stores only when the modified line is later evicted.

When an access misses, the CPU port stalls. The miss engine first picks a victim way in the set. If the victim holds modified data, that line is written out. The missing line is then fetched and installed. In the cycle after the fetch completes, the held request finds a hit and completes through the ordinary hit path, and this applies to stores as well. The processor must hold its request unchanged while ready is low. Only one miss is handled at a time.

Top module: `l1c_cache`

## Requirements
- R1: After reset every way of every set is invalid, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: Addresses are word aligned (bits [1:0] zero). Bits [5:2] select the word in the line, bits [10:6] select the set and bits [31:11] are the tag. Addresses with equal set bits and different tags compete for the same two ways, and addresses in different sets never disturb each other.
- R3: When a held request hits, `cpu_ready` is high in that same cycle and `cpu_rdata` carries the stored word of the matching way as it stood before any store in that cycle.
- R4: On a miss, `cpu_ready` stays low from the detecting cycle until the refill is acknowledged, and it rises in the cycle that follows the refill acknowledge.
- R5: A refill is a read transaction (`mem_we` low) at line address {tag, set, 6'b0}. Word k of the returned 512-bit line sits at bits [32k+31:32k].
- R6: A store hit writes byte i of `cpu_wdata` (bits [8i+7:8i]) only where `cpu_be[i]` is set, marks the line modified, and causes no memory transaction.
- R7: If the victim is valid and modified, a write transaction (`mem_we` high) carrying the victim's full line at the victim's line address is completed before the refill begins. A clean or invalid victim causes no write.
- R8: The victim is the first invalid way, checking way 0 before way 1. When both ways are valid, the way named by the set's recency bit is chosen.
- R9: Each hit, and each fill, sets the set's recency bit to the way that was not just used.
- R10: A store that misses first refills the line and then merges its bytes as a store hit would (write-allocate).
- R11: Once `mem_req` is raised, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`. Each acknowledge closes exactly one transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Store byte enables |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data of the hitting way |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = line write-back, 0 = line refill |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 512 | Victim line for write-back |
| mem_rdata | input | 512 | Refill line, valid with mem_ack |
| mem_ack | input | 1 | Transaction done this cycle |

## Verification
Two activities can land on the same set in close succession. The first is the write-back of a modified victim. The second is the refill of a new line that competes for that victim's place, and the refilled line can be the very line written back a few accesses earlier. The bench provokes this by dirtying a line with a partial store. It then steers two further tags into the same set, so the recency bit points at the modified way. Finally it requests the first line again. The behavioural model judges the outcome transaction by transaction: the write must come first and carry the merged bytes, the read must follow at the new line address, and the re-fetched word must show the merged value. Ready timing is compared on every cycle throughout.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } miss_state_e;

    typedef struct packed {
        miss_state_e state;
        logic        way;
    } miss_regs_t;

endpackage

// File: rtl/l1c_tag_store.sv
module l1c_tag_store
    import l1c_pkg::*;
#(
    parameter int SET_W = 5,
    parameter int TAG_W = 21
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SET_W-1:0]                lk_set,
    input  logic [TAG_W-1:0]                lk_tag,
    output logic [NUM_WAYS-1:0]             hit_vec,
    output logic                            vict_way,
    output logic                            vict_dirty,
    output logic [NUM_WAYS-1:0][TAG_W-1:0]  rd_tags,
    input  logic                            touch_en,
    input  logic                            touch_way,
    input  logic                            touch_dirty,
    input  logic                            fill_en,
    input  logic                            fill_way
);

    localparam int NUM_SETS = 1 << SET_W;

    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q [NUM_SETS];
    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_d [NUM_SETS];
    logic [NUM_WAYS-1:0]            vld_q [NUM_SETS];
    logic [NUM_WAYS-1:0]            vld_d [NUM_SETS];
    logic [NUM_WAYS-1:0]            drt_q [NUM_SETS];
    logic [NUM_WAYS-1:0]            drt_d [NUM_SETS];
    logic                           lru_q [NUM_SETS];
    logic                           lru_d [NUM_SETS];

    logic [NUM_WAYS-1:0] row_vld;
    logic [NUM_WAYS-1:0] row_drt;

    assign rd_tags = tag_q[lk_set];
    assign row_vld = vld_q[lk_set];
    assign row_drt = drt_q[lk_set];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = row_vld[w] && (rd_tags[w] == lk_tag);
    end

    always_comb begin
        if (!row_vld[0])      vict_way = 1'b0;
        else if (!row_vld[1]) vict_way = 1'b1;
        else                  vict_way = lru_q[lk_set];
        vict_dirty = row_vld[vict_way] && row_drt[vict_way];
    end

    always_comb begin
        tag_d = tag_q;
        vld_d = vld_q;
        drt_d = drt_q;
        lru_d = lru_q;
        if (fill_en) begin
            tag_d[lk_set][fill_way] = lk_tag;
            vld_d[lk_set][fill_way] = 1'b1;
            drt_d[lk_set][fill_way] = 1'b0;
            lru_d[lk_set]           = ~fill_way;
        end else if (touch_en) begin
            lru_d[lk_set] = ~touch_way;
            if (touch_dirty) drt_d[lk_set][touch_way] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                tag_q[s] <= '0;
                vld_q[s] <= '0;
                drt_q[s] <= '0;
                lru_q[s] <= 1'b0;
            end
        end else begin
            tag_q <= tag_d;
            vld_q <= vld_d;
            drt_q <= drt_d;
            lru_q <= lru_d;
        end
    end

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9
    fill_touch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && touch_en));

endmodule

// File: rtl/l1c_data_store.sv
module l1c_data_store
    import l1c_pkg::*;
#(
    parameter int SET_W  = 5,
    parameter int WSEL_W = 4,
    parameter int WORD_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [SET_W-1:0]                  set_idx,
    input  logic [WSEL_W-1:0]                 word_idx,
    output logic [NUM_WAYS-1:0][WORD_W-1:0]   rd_pair,
    input  logic                              wr_en,
    input  logic                              wr_way,
    input  logic [WORD_W/8-1:0]               wr_be,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic                              fill_en,
    input  logic                              fill_way,
    input  logic [(WORD_W<<WSEL_W)-1:0]       fill_line,
    input  logic                              ev_way,
    output logic [(WORD_W<<WSEL_W)-1:0]       ev_line
);

    localparam int ROW_W  = SET_W + WSEL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int WPL    = 1 << WSEL_W;
    localparam int BE_W   = WORD_W / 8;

    logic [NUM_WAYS-1:0][WORD_W-1:0] mem_q [ROWS];

    assign rd_pair = mem_q[{set_idx, word_idx}];

    for (genvar k = 0; k < WPL; k++) begin : g_evict
        assign ev_line[k*WORD_W +: WORD_W] = mem_q[{set_idx, WSEL_W'(k)}][ev_way];
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int k = 0; k < WPL; k++) begin
                mem_q[{set_idx, WSEL_W'(k)}][fill_way] <= fill_line[k*WORD_W +: WORD_W];
            end
        end else if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) mem_q[{set_idx, word_idx}][wr_way][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // R10
    no_merge_during_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && fill_en));

endmodule

// File: rtl/l1c_miss_fsm.sv
module l1c_miss_fsm
    import l1c_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SET_W  = 5,
    parameter int TAG_W  = 21,
    parameter int OFF_W  = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cpu_req,
    input  logic                            any_hit,
    input  logic                            vict_way,
    input  logic                            vict_dirty,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0]  rd_tags,
    input  logic [SET_W-1:0]                lk_set,
    input  logic [TAG_W-1:0]                lk_tag,
    input  logic                            mem_ack,
    output logic                            idle,
    output logic                            mem_req,
    output logic                            mem_we,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic                            fill_en,
    output logic                            sel_way
);

    miss_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        fill_en = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cpu_req && !any_hit) begin
                    r_d.way   = vict_way;
                    r_d.state = vict_dirty ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                if (mem_ack) r_d.state = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    fill_en   = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, way: 1'b0};
        else        r_q <= r_d;
    end

    assign idle     = (r_q.state == ST_IDLE);
    assign mem_req  = !idle;
    assign mem_we   = (r_q.state == ST_EVICT);
    assign sel_way  = r_q.way;
    assign mem_addr = mem_we ? {rd_tags[r_q.way], lk_set, {OFF_W{1'b0}}}
                             : {lk_tag, lk_set, {OFF_W{1'b0}}};

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R7
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

endmodule

// File: rtl/l1c_cache.sv
module l1c_cache
    import l1c_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int NUM_SETS   = 32,
    parameter int WORD_W     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [WORD_W/8-1:0]       cpu_be,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [WORD_W-1:0]         cpu_wdata,
    output logic                      cpu_ready,
    output logic [WORD_W-1:0]         cpu_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [LINE_BYTES*8-1:0]   mem_wdata,
    input  logic [LINE_BYTES*8-1:0]   mem_rdata,
    input  logic                      mem_ack
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - BOFF_W;

    logic [SET_W-1:0]                 lk_set;
    logic [TAG_W-1:0]                 lk_tag;
    logic [WSEL_W-1:0]                lk_word;
    logic [NUM_WAYS-1:0]              hit_vec;
    logic                             any_hit;
    logic                             hit_way;
    logic                             vict_way;
    logic                             vict_dirty;
    logic [NUM_WAYS-1:0][TAG_W-1:0]   rd_tags;
    logic [NUM_WAYS-1:0][WORD_W-1:0]  rd_pair;
    logic                             idle;
    logic                             fill_en;
    logic                             sel_way;

    assign lk_word = cpu_addr[OFF_W-1:BOFF_W];
    assign lk_set  = cpu_addr[OFF_W +: SET_W];
    assign lk_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    assign any_hit   = |hit_vec;
    assign hit_way   = hit_vec[1];
    assign cpu_ready = idle && cpu_req && any_hit;
    assign cpu_rdata = rd_pair[hit_way];

    l1c_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_set      (lk_set),
        .lk_tag      (lk_tag),
        .hit_vec     (hit_vec),
        .vict_way    (vict_way),
        .vict_dirty  (vict_dirty),
        .rd_tags     (rd_tags),
        .touch_en    (cpu_ready),
        .touch_way   (hit_way),
        .touch_dirty (cpu_we),
        .fill_en     (fill_en),
        .fill_way    (sel_way)
    );

    l1c_data_store #(.SET_W(SET_W), .WSEL_W(WSEL_W), .WORD_W(WORD_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (lk_set),
        .word_idx  (lk_word),
        .rd_pair   (rd_pair),
        .wr_en     (cpu_ready && cpu_we),
        .wr_way    (hit_way),
        .wr_be     (cpu_be),
        .wr_data   (cpu_wdata),
        .fill_en   (fill_en),
        .fill_way  (sel_way),
        .fill_line (mem_rdata),
        .ev_way    (sel_way),
        .ev_line   (mem_wdata)
    );

    l1c_miss_fsm #(.ADDR_W(ADDR_W), .SET_W(SET_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .any_hit    (any_hit),
        .vict_way   (vict_way),
        .vict_dirty (vict_dirty),
        .rd_tags    (rd_tags),
        .lk_set     (lk_set),
        .lk_tag     (lk_tag),
        .mem_ack    (mem_ack),
        .idle       (idle),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .fill_en    (fill_en),
        .sel_way    (sel_way)
    );

    // R2
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[BOFF_W-1:0] == '0));

    // R4
    ready_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && cpu_req) |=> cpu_ready);

    // R6
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

endmodule

// File: tb/sim_l1c_cache.sv
module sim_l1c_cache;

    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [3:0]   cpu_be = '0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic [511:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    always #4 clk = ~clk;

    l1c_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int nchk = 0;
    int nerr = 0;

    typedef struct {
        bit           we;
        logic [31:0]  addr;
        logic [511:0] data;
    } txn_t;
    txn_t txq[$];

    logic [31:0] bmem [int unsigned];

    logic [20:0] m_tag [32][2];
    bit          m_vld [32][2];
    bit          m_drt [32][2];
    bit          m_lru [32];
    logic [31:0] m_dat [32][2][16];

    function automatic int unsigned wkey(logic [20:0] t, logic [4:0] s, logic [3:0] k);
        return int'({2'b00, t, s, k});
    endfunction

    function automatic logic [31:0] mem_word(int unsigned wa);
        if (bmem.exists(wa)) return bmem[wa];
        return (wa * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic logic [31:0] mk(logic [20:0] t, logic [4:0] s, logic [3:0] k);
        return {t, s, k, 2'b00};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder: LAT cycles per transaction, one-cycle acknowledge
    int mcnt = 0;
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mcnt = 0;
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            mcnt = 1;
        end else begin
            mcnt++;
            if (mcnt == LAT) begin
                txn_t tx;
                logic [511:0] line;
                for (int k = 0; k < 16; k++)
                    line[k*32 +: 32] = mem_word(int'(mem_addr[31:2]) + k);
                tx.we   = mem_we;
                tx.addr = mem_addr;
                tx.data = mem_we ? mem_wdata : line;
                txq.push_back(tx);
                if (!mem_we) mem_rdata <= line;
                mem_ack <= 1'b1;
            end
        end
    end

    task automatic access(bit we, logic [3:0] be, logic [31:0] addr, logic [31:0] wd, string req);
        logic [4:0]  s = addr[10:6];
        logic [3:0]  w = addr[5:2];
        logic [20:0] t = addr[31:11];
        int hw = -1;
        int vw = 0;
        bit ewb = 0;
        int exp_cyc;
        int n = 0;
        bit got = 0;
        logic [31:0] rd = '0;
        logic [511:0] vline;

        for (int i = 0; i < 2; i++) if (m_vld[s][i] && m_tag[s][i] == t) hw = i;
        if (hw < 0) begin
            if (!m_vld[s][0])      vw = 0;
            else if (!m_vld[s][1]) vw = 1;
            else                   vw = int'(m_lru[s]);
            ewb = m_vld[s][vw] && m_drt[s][vw];
            exp_cyc = 2 + LAT + (ewb ? LAT : 0);
        end else exp_cyc = 1;

        txq.delete();
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = addr; cpu_wdata = wd;
        while (!got && n < exp_cyc + 6) begin
            #1;
            n++;
            if (cpu_ready) begin
                got = 1;
                rd = cpu_rdata;
            end else @(negedge clk);
        end
        chk(got && n == exp_cyc, {req, " R3 R4"}, "cycles to ready", 512'(n), 512'(exp_cyc));
        @(negedge clk);
        cpu_req = 1'b0;

        if (hw < 0) begin
            // R5 R7: transaction order and contents
            chk(txq.size() == (ewb ? 2 : 1), {req, " R7"}, "transaction count",
                512'(txq.size()), 512'(ewb ? 2 : 1));
            if (ewb) begin
                for (int k = 0; k < 16; k++) vline[k*32 +: 32] = m_dat[s][vw][k];
                if (txq.size() > 0) begin
                    chk(txq[0].we == 1'b1 && txq[0].addr == {m_tag[s][vw], s, 6'b0},
                        {req, " R7"}, "write-back address", 512'(txq[0].addr),
                        512'({m_tag[s][vw], s, 6'b0}));
                    chk(txq[0].data == vline, {req, " R7"}, "write-back line", txq[0].data, vline);
                end
                for (int k = 0; k < 16; k++) bmem[wkey(m_tag[s][vw], s, 4'(k))] = m_dat[s][vw][k];
            end
            if (txq.size() > 0)
                chk(txq[txq.size()-1].we == 1'b0 && txq[txq.size()-1].addr == {t, s, 6'b0},
                    {req, " R5"}, "refill address", 512'(txq[txq.size()-1].addr), 512'({t, s, 6'b0}));
            m_tag[s][vw] = t; m_vld[s][vw] = 1; m_drt[s][vw] = 0; m_lru[s] = ~1'(vw);
            for (int k = 0; k < 16; k++) m_dat[s][vw][k] = mem_word(wkey(t, s, 4'(k)));
            hw = vw;
        end else begin
            chk(txq.size() == 0, {req, " R6"}, "memory traffic on hit", 512'(txq.size()), 512'd0);
        end

        if (!we) chk(rd == m_dat[s][hw][w], {req, " R3"}, "load data", 512'(rd), 512'(m_dat[s][hw][w]));
        m_lru[s] = ~1'(hw);
        if (we) begin
            for (int b = 0; b < 4; b++) if (be[b]) m_dat[s][hw][w][b*8 +: 8] = wd[b*8 +: 8];
            m_drt[s][hw] = 1;
        end
    endtask

    initial begin
        #(8 * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int s = 0; s < 32; s++) begin
            m_lru[s] = 0;
            for (int i = 0; i < 2; i++) begin m_vld[s][i] = 0; m_drt[s][i] = 0; m_tag[s][i] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "idle after reset",
            512'({cpu_ready, mem_req}), 512'd0);

        access(0, 4'h0, mk(21'd5, 5'd3, 4'd2), '0, "R1 cold miss");
        access(0, 4'h0, mk(21'd5, 5'd3, 4'd2), '0, "R3 hit");
        access(1, 4'b0101, mk(21'd5, 5'd3, 4'd2), 32'hAABBCCDD, "R6 store hit");
        access(0, 4'h0, mk(21'd5, 5'd3, 4'd2), '0, "R6 merged read");
        access(0, 4'h0, mk(21'd9, 5'd3, 4'd7), '0, "R2 R8 invalid way first");
        access(0, 4'h0, mk(21'd5, 5'd3, 4'd3), '0, "R9 hit moves recency");
        access(0, 4'h0, mk(21'd12, 5'd3, 4'd0), '0, "R8 R9 clean victim");
        access(0, 4'h0, mk(21'd14, 5'd3, 4'd1), '0, "R7 dirty victim");
        access(0, 4'h0, mk(21'd5, 5'd3, 4'd2), '0, "R7 refetch merged");
        access(1, 4'b1100, mk(21'd3, 5'd20, 4'd5), 32'h12345678, "R10 store miss");
        access(0, 4'h0, mk(21'd3, 5'd20, 4'd5), '0, "R10 allocated read");
        access(0, 4'h0, mk(21'd3, 5'd21, 4'd5), '0, "R2 other set");
        access(0, 4'h0, mk(21'd3, 5'd20, 4'd5), '0, "R2 set kept");

        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            access(lf[0], lf[4:1], mk(21'(lf[7:6]) + 21'd1, lf[8] ? 5'd7 : 5'd8, lf[12:9]),
                   {lf, ~lf}, "R8 R9 R11 mixed");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule